// File: doc/BRIEF.md
# Count/Compare Timer Interrupt

This block is a system-control timer built from two registers of equal width: a free-running counter and a compare value. The counter advances once every `DIV` core clock cycles (two by default, half the core rate) and wraps silently from all ones back to zero. When the counter steps onto the compare value, a pending flag is set and drives the timer interrupt line. The flag stays set until software writes the compare register.

Software reaches both registers through one small access port. A one-bit select picks the register, a write strobe loads it from the write data, and the read data always shows the selected register. A write to the counter restarts the prescaler phase. Because a match is only recognised when the counter steps onto the compare value, loading the counter directly with that value does not raise the interrupt.

Top module: `tick_timer_top`

## Requirements
- R1: After reset the counter reads 0, the compare register reads 0 and `timer_irq` is low.
- R2: Without a counter write, the counter grows by exactly one every `DIV` clock cycles (default 2), and never on two consecutive cycles. The first increment after reset lands on the second clock edge.
- R3: A counter write (`reg_we`=1, `reg_sel`=0) loads `reg_wdata` at that clock edge and restarts the prescaler, so the next increment lands `DIV` edges after the write edge.
- R4: `reg_rdata` shows the counter when `reg_sel`=0 and the compare register when `reg_sel`=1, combinationally. A write with `reg_sel`=1 loads the compare register.
- R5: `timer_irq` rises on the same clock edge at which the counter increments onto the compare value.
- R6: Once raised, `timer_irq` stays high through further counting and through counter writes, until a compare write.
- R7: Any compare write drops `timer_irq` at that edge, including a write of the value already held.
- R8: A counter write of a value equal to the compare register does not raise `timer_irq`.
- R9: The counter wraps from all ones to zero with no interrupt unless the compare value is reached by that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 counter, 1 compare |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Selected register contents |
| timer_irq | output | 1 | Sticky timer interrupt |

## Verification
The assertions assume that `reg_sel` and `reg_we` are driven to known values in every cycle after reset, and that a single access changes only one register per cycle. The half-rate check also assumes a counter write is the only event other than prescaler ticks that can move the counter. The stimulus changes the access inputs only at the falling edge and returns the strobe to zero after each one-cycle write. It never overlaps accesses, so every property sees well-formed, isolated writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic {
      SEL_COUNT   = 1'b0,
      SEL_COMPARE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/tick_timer_prescale.sv
module tick_timer_prescale #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_full_rate
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int PH_W = $clog2(DIV);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
         logic [PH_W-1:0] phase_q;

         assign tick = (phase_q == PH_LAST);

         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               phase_q <= '0;
            end else if (tick) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + PH_W'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_next,
   output logic             step
);
   assign cnt_next = cnt_q + CNT_W'(1);
   assign step     = tick && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         cnt_q <= cnt_next;
      end
   end
endmodule

// File: rtl/tick_timer_match.sv
module tick_timer_match #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_load,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_next,
   output logic [CNT_W-1:0] cmp_q,
   output logic             pend_q
);
   logic hit;

   assign hit = step && (cnt_next == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_load) begin
         cmp_q <= cmp_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cmp_load) begin
         pend_q <= 1'b0;
      end else if (hit) begin
         pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int DIV   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_sel,
   input  logic             reg_we,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             timer_irq
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tick_timer_top: CNT_W must be at least 2");
      end
      if (DIV < 1) begin : g_bad_div
         $error("tick_timer_top: DIV must be at least 1");
      end
   endgenerate

   logic             cnt_wr;
   logic             cmp_wr;
   logic             tick;
   logic             step;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] cmp_q;

   assign cnt_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_COUNT);
   assign cmp_wr = reg_we && (reg_sel_e'(reg_sel) == SEL_COMPARE);

   tick_timer_prescale #(.DIV(DIV)) i_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cnt_wr),
      .tick    (tick)
   );

   tick_timer_counter #(.CNT_W(CNT_W)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_wr),
      .load_val (reg_wdata),
      .tick     (tick),
      .cnt_q    (cnt_q),
      .cnt_next (cnt_next),
      .step     (step)
   );

   tick_timer_match #(.CNT_W(CNT_W)) i_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_load (cmp_wr),
      .cmp_val  (reg_wdata),
      .step     (step),
      .cnt_next (cnt_next),
      .cmp_q    (cmp_q),
      .pend_q   (timer_irq)
   );

   assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_COMPARE) ? cmp_q : cnt_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W = 32,
   parameter int DIV   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_sel,
   input logic             reg_we,
   input logic [CNT_W-1:0] reg_wdata,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic             irq
);
   logic cnt_wr;
   logic cmp_wr;
   assign cnt_wr = reg_we && !reg_sel;
   assign cmp_wr = reg_we &&  reg_sel;

   a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

   generate
      if (DIV >= 2) begin : g_half
         a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != $past(cnt) && !cnt_wr) |=> (cnt == $past(cnt)));
      end
   endgenerate

   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(reg_wdata)));

   a_r5_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (cnt == cmp));

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cmp_wr) |=> irq);

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !irq);

   a_r8_no_fire_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !irq) |=> !irq);
endmodule

bind tick_timer_top tick_timer_chk #(.CNT_W(CNT_W), .DIV(DIV)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .cnt       (cnt_q),
   .cmp       (cmp_q),
   .irq       (timer_irq)
);

// File: tb/test_tick_timer_top.sv
`timescale 1ns/1ps
module test_tick_timer_top;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_sel = 1'b0;
   logic         reg_we = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         timer_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   tick_timer_top #(.CNT_W(W), .DIV(2)) i_tick_timer_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .timer_irq (timer_irq)
   );

   task automatic check(input logic ok, input string req,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_cnt(input string req, input logic [W-1:0] exp);
      reg_sel = 1'b0; #1;
      check(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic chk_irq(input string req, input logic exp);
      check(timer_irq == exp, req, W'(timer_irq), W'(exp));
   endtask

   // one-cycle write, entered and left at a falling edge
   task automatic wr(input logic sel, input logic [W-1:0] val);
      reg_sel = sel; reg_we = 1'b1; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(8ns * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
   end

   initial begin
      logic [W-1:0] v;
      logic [W-1:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_cnt("R1 count", '0);
      reg_sel = 1'b1; #1;
      check(reg_rdata == '0, "R1 compare", reg_rdata, '0);
      chk_irq("R1 irq", 1'b0);

      // R2 free run from reset: after k edges count is k/2
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         chk_cnt("R2 rate", W'(k / 2));
      end

      // R3/R5/R6/R9 sweep of distances and bases
      for (int d = 1; d <= 6; d++) begin
         v = (d == 6) ? 32'hFFFF_FFFC : (W'(d) * 32'h0101_0101);
         c = v + W'(d);
         wr(1'b0, v);
         chk_cnt("R3 load", v);
         if (d > 1) chk_irq("R6 held over count write", 1'b1);
         wr(1'b1, c);
         reg_sel = 1'b1; #1;
         check(reg_rdata == c, "R4 compare read", reg_rdata, c);
         for (int k = 1; k <= 2 * d + 4; k++) begin
            chk_cnt((d == 6) ? "R9 wrap count" : "R3 count after load", v + W'(k / 2));
            chk_irq((k >= 2 * d) ? "R6 sticky" : "R5 no early irq", k >= 2 * d);
            @(negedge clk);
         end
      end

      // R7 compare rewrite with same value clears
      c = 32'h0000_0002;
      check(timer_irq == 1'b1, "R7 pre pending", W'(timer_irq), 1);
      wr(1'b1, c);
      for (int k = 0; k < 8; k++) begin
         chk_irq("R7 cleared", 1'b0);
         @(negedge clk);
      end

      // R8 load counter equal to compare
      c = 32'h0000_1234;
      wr(1'b1, c);
      wr(1'b0, c);
      for (int k = 0; k < 6; k++) begin
         chk_cnt("R8 count", c + W'(k / 2));
         chk_irq("R8 no irq", 1'b0);
         @(negedge clk);
      end

      // R9 wrap with distant compare
      wr(1'b1, 32'h0000_0080);
      wr(1'b0, 32'hFFFF_FFFF);
      chk_cnt("R9 all ones", 32'hFFFF_FFFF);
      @(negedge clk); @(negedge clk);
      chk_cnt("R9 wrapped", '0);
      chk_irq("R9 no event", 1'b0);

      // R3 phase restart: load on an odd phase
      @(negedge clk);
      wr(1'b0, 32'h10);
      @(negedge clk);
      chk_cnt("R3 phase hold", 32'h10);
      @(negedge clk);
      chk_cnt("R3 phase step", 32'h11);

      finish_run();
   end
endmodule